// File: doc/BRIEF.md
# Pulse-Signalled Request/Grant Bus Arbiter

This block hands the local bus over to other bus masters. Each of the other masters has one bidirectional, active-low line. The whole exchange happens on that one line as three pulses, each one clock wide:

1. The master sends a request.
2. The arbiter answers with a grant.
3. The master later sends a release.

The arbiter follows the bus sequencer's current phase and the attributes of the transfer in progress. From these it decides when the bus may be given up. It floats the bus from the grant clock until the release, then returns ownership to the sequencer after one idle clock.

Each line is modelled as two signals: a sampled pin level, `rq_pin_n_i`, and an open-drain pull-low enable, `rq_pull_o`. The pin level is low whenever the arbiter or the master pulls the line.

The sequencer phase arrives on `seq_state_i` as a 3-bit code: 0 idle, 1 first clock, 2 second clock, 3 third clock, 4 wait clock, 5 final clock. A lower channel index wins over a higher one.

Top module: `rqgt_arbiter`

## Requirements
- R1: While `rst_n` is low, `rq_pull_o`, `bus_float_o`, `reclaim_o` and `resume_t4_o` are all 0.
- R2: A request pulse (pin low for one clock) arriving while the sequencer is idle (code 0) sets a pending request. If the sequencer is still idle in the next clock, the grant pulse is driven in the clock after that.
- R3: The grant is a single clock of `rq_pull_o` high on the chosen channel's bit only. `bus_float_o` rises in that same clock and stays high until the release is taken.
- R4: A request arriving in the idle, first, second or final clock is eligible at the next final clock (code 5). The grant pulse follows in the clock after that final clock.
- R5: A request arriving in the third clock or a wait clock (code 3 or 4) is not granted at that transfer's final clock. It is granted at the following final clock.
- R6: A final clock with `low_byte_i` or `first_ack_i` high grants nothing. The pending request stays recorded.
- R7: While `lock_i` is high, no grant is issued. A request recorded during lock is granted once lock is low.
- R8: Requests arriving on both channels in the same clock are served channel 0 first. Channel 1 is served after channel 0's exchange has completed.
- R9: A low pin on the granted channel while the bus is held ends the hold. In the next clock, `bus_float_o` is 0, `reclaim_o` is 1 for one clock, and `resume_t4_o` equals `cycle_pend_i` as sampled with the release.
- R10: Pin pulses during the reclaim clock are ignored, so no grant follows from them.
- R11: During a grant, the arbiter's own pull on the granted line is not taken as a release. Pulses on a channel that is not granted leave the hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_pin_n_i | input | NUM_CH | Sampled level of each request/grant line (low = pulse) |
| rq_pull_o | output | NUM_CH | Open-drain pull-low enable per line (grant pulse) |
| seq_state_i | input | 3 | Sequencer phase code (0 idle, 1..3 first..third, 4 wait, 5 final) |
| low_byte_i | input | 1 | Current transfer is the low byte of a word |
| first_ack_i | input | 1 | Current transfer is the first of two acknowledge cycles |
| lock_i | input | 1 | Locked instruction executing |
| cycle_pend_i | input | 1 | Sequencer has a transfer waiting |
| bus_float_o | output | 1 | Bus, status, lock and status-pin lines at floated logic one |
| reclaim_o | output | 1 | One-clock pulse: bus returns to the sequencer |
| resume_t4_o | output | 1 | With `reclaim_o`: resume at the final clock (else at the first clock) |

## Verification
The bench targets the following corner cases:

- **Late request.** A request arrives in the third clock. A design that grants at that same transfer's final clock would release the bus mid-exchange.
- **Blocked final clock.** A final clock carries the low-byte or first-acknowledge flag. A design that ignored these flags would split a word transfer or an acknowledge pair.
- **Own pull and reclaim clock.** The arbiter's own pull is seen on the pin, and pulses land during the reclaim clock. A design that treated these as releases or new requests would end the grant at once or start an exchange without the idle clock.
- **Simultaneous requests and lock.** Both channels request together, and requests arrive under lock. Here a wrong design would grant channel 1 first, or break a locked sequence.

Random phases and flags are then checked clock by clock against a bench model.

// File: rtl/rqgt_pkg.sv
package rqgt_pkg;
    // sequencer phase codes
    localparam logic [2:0] SEQ_TI = 3'd0;
    localparam logic [2:0] SEQ_T1 = 3'd1;
    localparam logic [2:0] SEQ_T2 = 3'd2;
    localparam logic [2:0] SEQ_T3 = 3'd3;
    localparam logic [2:0] SEQ_TW = 3'd4;
    localparam logic [2:0] SEQ_T4 = 3'd5;

    typedef enum logic [1:0] {
        ARB_OWN   = 2'd0,
        ARB_GRANT = 2'd1,
        ARB_HELD  = 2'd2,
        ARB_GAP   = 2'd3
    } arb_e;

    typedef struct packed {
        logic pend;
        logic elig;
    } chan_t;
endpackage

// File: rtl/rqgt_chan_track.sv
module rqgt_chan_track
    import rqgt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_low_i,
    input  logic accept_i,
    input  logic clear_i,
    input  logic early_i,
    input  logic at_t4_i,
    output logic pend_o,
    output logic elig_o
);
    chan_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (clear_i) begin
            trk_d.pend = 1'b0;
            trk_d.elig = 1'b0;
        end else if (accept_i && !trk_q.pend && pin_low_i) begin
            // new request: eligible for this transfer only if it came early
            trk_d.pend = 1'b1;
            trk_d.elig = early_i;
        end else if (trk_q.pend && at_t4_i) begin
            // a late request becomes eligible once a final clock has passed
            trk_d.elig = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign pend_o = trk_q.pend;
    assign elig_o = trk_q.elig;
endmodule

// File: rtl/rqgt_prio_pick.sv
module rqgt_prio_pick #(
    parameter int N = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand_i,
    output logic [N-1:0]  pick_oh_o,
    output logic [IW-1:0] pick_idx_o,
    output logic          any_o
);
    // lowest index wins
    always_comb begin
        pick_oh_o  = '0;
        pick_idx_o = '0;
        any_o      = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                pick_oh_o  = '0;
                pick_oh_o[i] = 1'b1;
                pick_idx_o = IW'(i);
                any_o      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rqgt_arbiter.sv
module rqgt_arbiter
    import rqgt_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] rq_pin_n_i,
    output logic [NUM_CH-1:0] rq_pull_o,
    input  logic [2:0]        seq_state_i,
    input  logic              low_byte_i,
    input  logic              first_ack_i,
    input  logic              lock_i,
    input  logic              cycle_pend_i,
    output logic              bus_float_o,
    output logic              reclaim_o,
    output logic              resume_t4_o
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        arb_e            st;
        logic [CH_W-1:0] ch;
        logic            resume;
    } arb_t;

    arb_t arb_d, arb_q;

    logic [NUM_CH-1:0] pin_low, pend, elig, cand, pick_oh;
    logic [CH_W-1:0]   pick_idx;
    logic              pick_any, go, early, at_t4, bus_idle, t4_open;

    assign pin_low  = ~rq_pin_n_i;
    assign bus_idle = (seq_state_i == SEQ_TI);
    assign at_t4    = (seq_state_i == SEQ_T4);
    assign early    = (seq_state_i == SEQ_TI) || (seq_state_i == SEQ_T1) ||
                      (seq_state_i == SEQ_T2) || (seq_state_i == SEQ_T4);
    assign t4_open  = at_t4 && !low_byte_i && !first_ack_i;

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_chan
            rqgt_chan_track u_trk (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_low_i(pin_low[c]),
                .accept_i (arb_q.st == ARB_OWN),
                .clear_i  (go && pick_oh[c]),
                .early_i  (early),
                .at_t4_i  (at_t4),
                .pend_o   (pend[c]),
                .elig_o   (elig[c])
            );
            assign rq_pull_o[c] = (arb_q.st == ARB_GRANT) && (arb_q.ch == CH_W'(c));
        end
    endgenerate

    always_comb begin
        if (bus_idle)     cand = pend;
        else if (t4_open) cand = pend & elig;
        else              cand = '0;
    end

    rqgt_prio_pick #(.N(NUM_CH)) u_pick (
        .cand_i    (cand),
        .pick_oh_o (pick_oh),
        .pick_idx_o(pick_idx),
        .any_o     (pick_any)
    );

    assign go = (arb_q.st == ARB_OWN) && !lock_i && pick_any;

    always_comb begin
        arb_d = arb_q;
        unique case (arb_q.st)
            ARB_OWN: begin
                if (go) begin
                    arb_d.st = ARB_GRANT;
                    arb_d.ch = pick_idx;
                end
            end
            ARB_GRANT: arb_d.st = ARB_HELD;
            ARB_HELD: begin
                if (pin_low[arb_q.ch]) begin
                    arb_d.st     = ARB_GAP;
                    arb_d.resume = cycle_pend_i;
                end
            end
            ARB_GAP: arb_d.st = ARB_OWN;
            default: arb_d.st = ARB_OWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= '{st: ARB_OWN, ch: '0, resume: 1'b0};
        else        arb_q <= arb_d;
    end

    assign bus_float_o = (arb_q.st == ARB_GRANT) || (arb_q.st == ARB_HELD);
    assign reclaim_o   = (arb_q.st == ARB_GAP);
    assign resume_t4_o = (arb_q.st == ARB_GAP) && arb_q.resume;
endmodule

// File: rtl/rqgt_arbiter_chk.sv
module rqgt_arbiter_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] rq_pull_o,
    input logic [2:0]        seq_state_i,
    input logic              low_byte_i,
    input logic              first_ack_i,
    input logic              lock_i,
    input logic              bus_float_o,
    input logic              reclaim_o
);
    p_pull_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rq_pull_o));
    p_pull_one_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|rq_pull_o) |=> (rq_pull_o == '0));
    p_pull_floats_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|rq_pull_o) |-> bus_float_o);
    p_float_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_float_o) |-> (|rq_pull_o));
    p_grant_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|rq_pull_o) |-> ($past(seq_state_i) == 3'd0 || $past(seq_state_i) == 3'd5));
    p_t4_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rq_pull_o) && $past(seq_state_i) == 3'd5) |-> (!$past(low_byte_i) && !$past(first_ack_i)));
    p_no_grant_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|rq_pull_o) |-> !$past(lock_i));
    p_reclaim_after_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_float_o) |-> reclaim_o);
    p_gap_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reclaim_o |=> (rq_pull_o == '0 && !bus_float_o));
endmodule

bind rqgt_arbiter rqgt_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rq_pull_o  (rq_pull_o),
    .seq_state_i(seq_state_i),
    .low_byte_i (low_byte_i),
    .first_ack_i(first_ack_i),
    .lock_i     (lock_i),
    .bus_float_o(bus_float_o),
    .reclaim_o  (reclaim_o)
);

// File: tb/tb_rqgt_arbiter.sv
`timescale 1ns/1ps
module tb_rqgt_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_low = 2'b00;
    logic [1:0] rq_pin_n;
    logic [1:0] rq_pull;
    logic [2:0] seq = 3'd0;
    logic       lb = 1'b0, fa = 1'b0, lock = 1'b0, cpend = 1'b0;
    logic       bus_float, reclaim, resume_t4;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    int   m_st = 0;
    int   m_ch = 0;
    logic m_res = 1'b0;
    logic [1:0] m_pend = 2'b00, m_elig = 2'b00;

    always #2.5 clk = ~clk;

    // wired line: low when either side pulls
    assign rq_pin_n = ~(rq_pull | ext_low);

    rqgt_arbiter #(.NUM_CH(2)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rq_pin_n_i  (rq_pin_n),
        .rq_pull_o   (rq_pull),
        .seq_state_i (seq),
        .low_byte_i  (lb),
        .first_ack_i (fa),
        .lock_i      (lock),
        .cycle_pend_i(cpend),
        .bus_float_o (bus_float),
        .reclaim_o   (reclaim),
        .resume_t4_o (resume_t4)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic is_early(input logic [2:0] s);
        return (s == 3'd0) || (s == 3'd1) || (s == 3'd2) || (s == 3'd5);
    endfunction

    function automatic logic [1:0] exp_pull();
        return (m_st == 1) ? (2'b01 << m_ch) : 2'b00;
    endfunction

    task automatic model_step();
        logic [1:0] pl, cand, np, ne;
        logic go;
        int pick;
        if (!rst_n) begin
            m_st = 0; m_ch = 0; m_res = 1'b0; m_pend = 2'b00; m_elig = 2'b00;
            return;
        end
        pl = ~rq_pin_n;
        go = 1'b0; pick = 0; cand = 2'b00;
        if (m_st == 0 && !lock) begin
            if (seq == 3'd0) cand = m_pend;
            else if (seq == 3'd5 && !lb && !fa) cand = m_pend & m_elig;
            if (cand[0]) begin go = 1'b1; pick = 0; end
            else if (cand[1]) begin go = 1'b1; pick = 1; end
        end
        np = m_pend; ne = m_elig;
        for (int c = 0; c < 2; c++) begin
            if (go && pick == c) begin np[c] = 1'b0; ne[c] = 1'b0; end
            else if (m_st == 0 && !m_pend[c] && pl[c]) begin np[c] = 1'b1; ne[c] = is_early(seq); end
            else if (m_pend[c] && seq == 3'd5) ne[c] = 1'b1;
        end
        m_pend = np; m_elig = ne;
        case (m_st)
            0: if (go) begin m_st = 1; m_ch = pick; end
            1: m_st = 2;
            2: if (pl[m_ch]) begin m_st = 3; m_res = cpend; end
            default: m_st = 0;
        endcase
    endtask

    task automatic compare_all();
        chk("R2 model pull", {6'd0, rq_pull}, {6'd0, exp_pull()});
        chk("R3 model float", {7'd0, bus_float}, {7'd0, (m_st == 1 || m_st == 2)});
        chk("R9 model reclaim", {7'd0, reclaim}, {7'd0, (m_st == 3)});
        chk("R9 model resume", {7'd0, resume_t4}, {7'd0, (m_st == 3 && m_res)});
    endtask

    task automatic cyc();
        #1;
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    // expects the grant clock to be visible now
    task automatic release_ch(input int ch, input logic cp);
        cpend = cp;
        cyc();
        ext_low[ch] = 1'b1;
        cyc();
        ext_low = 2'b00;
        chk("R9 reclaim", {7'd0, reclaim}, 8'd1);
        chk("R9 resume", {7'd0, resume_t4}, {7'd0, cp});
        cyc();
    endtask

    initial begin
        void'($urandom(32'd1729));
        // R1 reset state
        cyc(); cyc();
        chk("R1 pull", {6'd0, rq_pull}, 8'd0);
        chk("R1 float", {7'd0, bus_float}, 8'd0);
        chk("R1 reclaim", {6'd0, reclaim, resume_t4}, 8'd0);
        rst_n = 1'b1;
        cyc(); cyc();

        // R2 idle request, R3 pulse shape, R11 own pull and foreign pulse, R9, R10
        ext_low = 2'b01; cyc(); ext_low = 2'b00;
        chk("R2 no early grant", {6'd0, rq_pull}, 8'd0);
        cyc();
        chk("R2 grant ch0", {6'd0, rq_pull}, 8'd1);
        chk("R3 float in grant", {7'd0, bus_float}, 8'd1);
        cpend = 1'b1;
        cyc();
        chk("R3 pulse one clock", {6'd0, rq_pull}, 8'd0);
        chk("R11 own pull not a release", {7'd0, bus_float}, 8'd1);
        ext_low = 2'b10; cyc(); ext_low = 2'b00;
        chk("R11 foreign pulse ignored", {7'd0, bus_float}, 8'd1);
        ext_low = 2'b01; cyc(); ext_low = 2'b00;
        chk("R9 float off", {7'd0, bus_float}, 8'd0);
        chk("R9 reclaim", {7'd0, reclaim}, 8'd1);
        chk("R9 resume at final", {7'd0, resume_t4}, 8'd1);
        ext_low = 2'b10; cyc(); ext_low = 2'b00;
        chk("R9 reclaim one clock", {7'd0, reclaim}, 8'd0);
        for (int k = 0; k < 4; k++) begin
            cyc();
            chk("R10 gap pulse ignored", {6'd0, rq_pull}, 8'd0);
        end
        cpend = 1'b0;

        // R8 priority
        ext_low = 2'b11; cyc(); ext_low = 2'b00;
        cyc();
        chk("R8 ch0 first", {6'd0, rq_pull}, 8'd1);
        release_ch(0, 1'b0);
        cyc();
        chk("R8 ch1 after", {6'd0, rq_pull}, 8'd2);
        release_ch(1, 1'b0);

        // R7 lock
        lock = 1'b1;
        ext_low = 2'b01; cyc(); ext_low = 2'b00;
        for (int k = 0; k < 4; k++) begin
            cyc();
            chk("R7 held under lock", {6'd0, rq_pull}, 8'd0);
        end
        lock = 1'b0;
        cyc();
        chk("R7 granted after lock", {6'd0, rq_pull}, 8'd1);
        release_ch(0, 1'b0);

        // R4 early request in second clock
        seq = 3'd2; ext_low = 2'b01; cyc(); ext_low = 2'b00;
        seq = 3'd3; cyc();
        chk("R4 not before final", {6'd0, rq_pull}, 8'd0);
        seq = 3'd5; cyc();
        seq = 3'd1;
        chk("R4 grant after final", {6'd0, rq_pull}, 8'd1);
        release_ch(0, 1'b1);

        // R5 late request in third clock
        seq = 3'd3; ext_low = 2'b01; cyc(); ext_low = 2'b00;
        seq = 3'd5; cyc();
        chk("R5 not this final", {6'd0, rq_pull}, 8'd0);
        seq = 3'd1; cyc();
        chk("R5 still waiting", {6'd0, rq_pull}, 8'd0);
        seq = 3'd2; cyc();
        seq = 3'd3; cyc();
        seq = 3'd5; cyc();
        seq = 3'd1;
        chk("R5 next final", {6'd0, rq_pull}, 8'd1);
        release_ch(0, 1'b0);

        // R6 low byte and first acknowledge defer
        seq = 3'd1; ext_low = 2'b01; cyc(); ext_low = 2'b00;
        seq = 3'd5; lb = 1'b1; cyc();
        chk("R6 low byte defers", {6'd0, rq_pull}, 8'd0);
        lb = 1'b0; seq = 3'd1; cyc();
        seq = 3'd5; fa = 1'b1; cyc();
        chk("R6 first ack defers", {6'd0, rq_pull}, 8'd0);
        fa = 1'b0; seq = 3'd1; cyc();
        seq = 3'd5; cyc();
        seq = 3'd0;
        chk("R6 granted on clean final", {6'd0, rq_pull}, 8'd1);
        release_ch(0, 1'b0);

        // random phase against model
        for (int k = 0; k < 3000; k++) begin
            seq   = 3'($urandom_range(0, 5));
            lock  = ($urandom % 6) == 0;
            lb    = ($urandom % 4) == 0;
            fa    = ($urandom % 4) == 0;
            cpend = $urandom % 2;
            ext_low[0] = ($urandom % 8) == 0;
            ext_low[1] = ($urandom % 8) == 0;
            cyc();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule